// File: doc/BRIEF.md
# Commanded Single-Frame Capture Engine

This block takes exactly one image frame from a parallel camera port each time a central controller asks for one, and writes it into buffer memory. While idle it ignores the camera entirely. A start command latches a base address and arms the block. Capture then begins at the next pixel that carries the frame-start marker. Every pixel of the frame, one per camera clock, is zero-extended from 12 to 16 bits. Each word goes out on a memory write port at the base address plus the pixel's index within the frame.

The camera bus has a valid strobe but no ready, because the camera cannot be stalled. The memory port is valid/ready. The rules for back-pressure are these. While `mem_valid_o` is high and `mem_ready_i` is low, the address and data are held unchanged, and a word counts as transferred on any clock edge where both are high. Words that are waiting sit in a small skid buffer. If the buffer is full when a pixel arrives, that pixel is dropped, its address slot stays unwritten, and a sticky overflow flag is raised for the frame.

When every pixel of the frame has arrived and every buffered word has been accepted by memory, the block raises a one-cycle completion pulse. The pulse carries the base address, the frame length in words, and the overflow flag. The block then returns to idle. Start commands that arrive while a capture is in progress are discarded and counted.

Top module: `frame_grab_ctrl`

## Requirements
- R1: While `busy_o` is low, camera pixels are ignored and `mem_valid_o` stays low. A `start_i` sampled high while idle latches `base_addr_i` and makes `busy_o` high from the next cycle.
- R2: After a start, pixels are discarded until a valid pixel arrives with `pix_sof_i` high. That pixel is pixel 0 of the frame. Within the frame, `pix_sof_i` has no effect, and every valid pixel counts as the next pixel.
- R3: Pixel i of the frame (0-based) is written at address base + i, and the pixel's 12 bits sit in data bits [11:0] with bits [15:12] zero.
- R4: Stored words leave the memory port in pixel order. While `mem_valid_o` is high and `mem_ready_i` is low, `mem_addr_o` and `mem_data_o` hold and `mem_valid_o` stays high.
- R5: The skid buffer holds SKID_DEPTH words. A pixel that arrives while SKID_DEPTH words are waiting is dropped without being written, and `done_ovf_o` is reported as 1 for that frame.
- R6: `done_o` pulses for exactly one cycle, and only after all FRAME_W*FRAME_H pixels have arrived and all stored words have been accepted. In that cycle `done_addr_o` equals the latched base, `done_len_o` equals FRAME_W*FRAME_H, and `done_ovf_o` gives the overflow flag.
- R7: In the cycle after `done_o`, `busy_o` is low and a new start is accepted. The overflow flag is cleared by each accepted start.
- R8: A `start_i` sampled high while `busy_o` is high does not change the capture or its base address. It increments `rej_cnt_o` by one, saturating at all ones. `rej_cnt_o` is not cleared between frames.
- R9: After reset, `busy_o`, `mem_valid_o`, `done_o` and `rej_cnt_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture command from the controller |
| base_addr_i | input | AW | Base word address, sampled with an accepted start |
| pix_valid_i | input | 1 | Camera pixel present |
| pix_sof_i | input | 1 | Marks the first pixel of a frame |
| pix_data_i | input | PIX_W | Pixel value |
| mem_valid_o | output | 1 | Memory write request |
| mem_ready_i | input | 1 | Memory accepts the write |
| mem_addr_o | output | AW | Write word address |
| mem_data_o | output | 16 | Write data, pixel zero-extended |
| busy_o | output | 1 | Capture in progress |
| done_o | output | 1 | One-cycle completion notice |
| done_addr_o | output | AW | Base address of the stored frame |
| done_len_o | output | LEN_W | Frame length in words |
| done_ovf_o | output | 1 | A pixel was dropped in this frame |
| rej_cnt_o | output | REJ_W | Saturating count of refused starts |

## Verification
The assertions check, on every cycle, the properties that can be stated locally. They check that nothing is written while idle, that a stalled write holds its address and data, and that the upper data bits are zero. They also check that the completion pulse is single, comes with the buffer empty, and is followed by idle, and that the refused-start counter steps or holds correctly. Other behaviour can only be shown by the bench's scenarios on a 4x3 frame. These include the order and the addresses of a whole frame, the discarding of pixels before the frame-start marker, the loss of exactly the pixels that arrive after a full buffer, and the base address surviving a refused start. The bench compares every stored word against arithmetic from the frame and pixel index.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,
    S_CAPT,
    S_DRAIN,
    S_NOTIFY
  } fg_state_e;

  localparam int unsigned WORD_W = 16;

  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/fg_pack.sv
module fg_pack #(
  parameter int unsigned AW    = 32,
  parameter int unsigned PIX_W = 12,
  parameter int unsigned CNT_W = 24
) (
  input  logic [PIX_W-1:0]         pix_i,
  input  logic [AW-1:0]            base_i,
  input  logic [CNT_W-1:0]         idx_i,
  output logic [fg_pkg::WORD_W-1:0] word_o,
  output logic [AW-1:0]            addr_o
);
  localparam int unsigned PAD_W = fg_pkg::WORD_W - PIX_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word_o = {{PAD_W{1'b0}}, pix_i};
    end else begin : g_nopad
      assign word_o = pix_i[fg_pkg::WORD_W-1:0];
    end
  endgenerate

  generate
    if (CNT_W >= AW) begin : g_idx_wide
      assign addr_o = base_i + idx_i[AW-1:0];
    end else begin : g_idx_narrow
      assign addr_o = base_i + {{(AW-CNT_W){1'b0}}, idx_i};
    end
  endgenerate
endmodule

// File: rtl/fg_skid.sv
module fg_skid #(
  parameter int unsigned DW    = 48,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  output logic          full_o,
  output logic          empty_o,
  output logic [DW-1:0] dout_o,
  input  logic          pop_i
);
  localparam int unsigned PW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (do_push && wr_q == PW'(g)) mem_q[g] <= din_i;
      end
    end
  endgenerate
endmodule

// File: rtl/fg_seq.sv
module fg_seq #(
  parameter int unsigned AW        = 32,
  parameter int unsigned FRAME_PIX = 16,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned REJ_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [AW-1:0]    base_addr_i,
  input  logic             pix_valid_i,
  input  logic             pix_sof_i,
  input  logic             buf_full_i,
  input  logic             buf_empty_i,
  output logic             push_o,
  output logic [CNT_W-1:0] idx_o,
  output logic [AW-1:0]    base_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovf_o,
  output logic [REJ_W-1:0] rej_o
);
  import fg_pkg::*;

  fg_state_e        st_q;
  logic [CNT_W-1:0] idx_q;
  logic [AW-1:0]    base_q;
  logic             ovf_q;
  logic [REJ_W-1:0] rej_q;
  logic             accept, last_pix;

  assign accept   = pix_valid_i && ((st_q == S_CAPT) || (st_q == S_ARM && pix_sof_i));
  assign last_pix = (idx_q == CNT_W'(FRAME_PIX - 1));
  assign push_o   = accept && !buf_full_i;
  assign idx_o    = idx_q;
  assign base_o   = base_q;
  assign busy_o   = (st_q != S_IDLE);
  assign done_o   = (st_q == S_NOTIFY);
  assign ovf_o    = ovf_q;
  assign rej_o    = rej_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      base_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q   <= S_ARM;
          base_q <= base_addr_i;
          idx_q  <= '0;
          ovf_q  <= 1'b0;
        end
        S_ARM, S_CAPT: if (accept) begin
          if (buf_full_i) ovf_q <= 1'b1;
          if (last_pix) begin
            st_q <= S_DRAIN;
          end else begin
            st_q  <= S_CAPT;
            idx_q <= idx_q + CNT_W'(1);
          end
        end
        S_DRAIN:  if (buf_empty_i) st_q <= S_NOTIFY;
        S_NOTIFY: st_q <= S_IDLE;
        default:  st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rej_q <= '0;
    end else if (start_i && busy_o && rej_q != '1) begin
      rej_q <= rej_q + REJ_W'(1);
    end
  end
endmodule

// File: rtl/frame_grab_ctrl.sv
module frame_grab_ctrl #(
  parameter int unsigned AW         = 32,
  parameter int unsigned PIX_W      = 12,
  parameter int unsigned FRAME_W    = 3664,
  parameter int unsigned FRAME_H    = 2748,
  parameter int unsigned SKID_DEPTH = 4,
  parameter int unsigned REJ_W      = 8,
  parameter int unsigned LEN_W      = fg_pkg::cnt_bits(FRAME_W * FRAME_H)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [AW-1:0]    base_addr_i,
  input  logic             pix_valid_i,
  input  logic             pix_sof_i,
  input  logic [PIX_W-1:0] pix_data_i,
  output logic             mem_valid_o,
  input  logic             mem_ready_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic [15:0]      mem_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [AW-1:0]    done_addr_o,
  output logic [LEN_W-1:0] done_len_o,
  output logic             done_ovf_o,
  output logic [REJ_W-1:0] rej_cnt_o
);
  localparam int unsigned FRAME_PIX = FRAME_W * FRAME_H;
  localparam int unsigned CNT_W     = fg_pkg::cnt_bits(FRAME_PIX);
  localparam int unsigned ENT_W     = AW + fg_pkg::WORD_W;

  logic             push, full, empty;
  logic [CNT_W-1:0] idx;
  logic [AW-1:0]    base, wr_addr;
  logic [15:0]      wr_word;
  logic [ENT_W-1:0] head;

  fg_seq #(.AW(AW), .FRAME_PIX(FRAME_PIX), .CNT_W(CNT_W), .REJ_W(REJ_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .pix_valid_i(pix_valid_i), .pix_sof_i(pix_sof_i),
    .buf_full_i(full), .buf_empty_i(empty),
    .push_o(push), .idx_o(idx), .base_o(base), .busy_o(busy_o),
    .done_o(done_o), .ovf_o(done_ovf_o), .rej_o(rej_cnt_o)
  );

  fg_pack #(.AW(AW), .PIX_W(PIX_W), .CNT_W(CNT_W)) u_pack (
    .pix_i(pix_data_i), .base_i(base), .idx_i(idx),
    .word_o(wr_word), .addr_o(wr_addr)
  );

  fg_skid #(.DW(ENT_W), .DEPTH(SKID_DEPTH)) u_skid (
    .clk(clk), .rst_n(rst_n), .push_i(push), .din_i({wr_addr, wr_word}),
    .full_o(full), .empty_o(empty), .dout_o(head), .pop_i(mem_ready_i)
  );

  assign mem_valid_o = !empty;
  assign mem_addr_o  = head[ENT_W-1:fg_pkg::WORD_W];
  assign mem_data_o  = head[fg_pkg::WORD_W-1:0];
  assign done_addr_o = base;
  assign done_len_o  = LEN_W'(FRAME_PIX);
endmodule

// File: rtl/fg_chk.sv
module fg_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned PIX_W = 12,
  parameter int unsigned REJ_W = 8,
  parameter int unsigned LEN_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             mem_valid_o,
  input logic             mem_ready_i,
  input logic [AW-1:0]    mem_addr_o,
  input logic [15:0]      mem_data_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [REJ_W-1:0] rej_cnt_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_valid_o); // R1

  AST_ZERO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |-> (mem_data_o >> PIX_W) == 16'd0); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)); // R4

  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o && !mem_valid_o); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o); // R7

  AST_REJ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && rej_cnt_o != {REJ_W{1'b1}} |=> rej_cnt_o == $past(rej_cnt_o) + REJ_W'(1)); // R8

  AST_REJ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && start_i) |=> $stable(rej_cnt_o)); // R8
endmodule

bind frame_grab_ctrl fg_chk #(.AW(AW), .PIX_W(PIX_W), .REJ_W(REJ_W), .LEN_W(LEN_W)) i_fg_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .mem_valid_o(mem_valid_o),
  .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
  .busy_o(busy_o), .done_o(done_o), .rej_cnt_o(rej_cnt_o)
);

// File: tb/test_frame_grab_ctrl.sv
module test_frame_grab_ctrl;
  localparam int AW = 16, PIX_W = 12, FW = 4, FH = 3, DEPTH = 4, REJ_W = 3;
  localparam int FP = FW * FH;
  localparam int LEN_W = $clog2(FP + 1);

  logic clk = 0, rst_n = 0;
  logic start_i = 0, pix_valid_i = 0, pix_sof_i = 0, mem_ready_i = 1;
  logic [AW-1:0] base_addr_i = '0;
  logic [PIX_W-1:0] pix_data_i = '0;
  logic mem_valid_o, busy_o, done_o, done_ovf_o;
  logic [AW-1:0] mem_addr_o, done_addr_o;
  logic [15:0] mem_data_o;
  logic [LEN_W-1:0] done_len_o;
  logic [REJ_W-1:0] rej_cnt_o;

  int checks = 0, fails = 0;
  int wr_n = 0, done_n = 0;
  logic [AW-1:0] wr_addr [64];
  logic [15:0] wr_data [64];
  logic [AW-1:0] d_addr;
  logic [LEN_W-1:0] d_len;
  logic d_ovf;

  always #5 clk = ~clk;

  frame_grab_ctrl #(.AW(AW), .PIX_W(PIX_W), .FRAME_W(FW), .FRAME_H(FH),
                    .SKID_DEPTH(DEPTH), .REJ_W(REJ_W)) i_frame_grab_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .pix_valid_i(pix_valid_i), .pix_sof_i(pix_sof_i), .pix_data_i(pix_data_i),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o),
    .mem_data_o(mem_data_o), .busy_o(busy_o), .done_o(done_o),
    .done_addr_o(done_addr_o), .done_len_o(done_len_o), .done_ovf_o(done_ovf_o),
    .rej_cnt_o(rej_cnt_o)
  );

  always @(negedge clk) begin
    if (rst_n && mem_valid_o && mem_ready_i && wr_n < 64) begin
      wr_addr[wr_n] = mem_addr_o;
      wr_data[wr_n] = mem_data_o;
      wr_n++;
    end
    if (rst_n && done_o) begin
      d_addr = done_addr_o; d_len = done_len_o; d_ovf = done_ovf_o;
      done_n++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PIX_W-1:0] pix(input int fid, input int i);
    return PIX_W'((fid * 977 + i * 131 + 12'hA05) & 12'hFFF);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic drive(input bit v, input bit sof, input logic [PIX_W-1:0] d);
    tick();
    pix_valid_i = v; pix_sof_i = sof; pix_data_i = d;
  endtask

  task automatic cmd_start(input logic [AW-1:0] b);
    tick(); start_i = 1; base_addr_i = b;
    tick(); start_i = 0; base_addr_i = 16'hDEAD;
  endtask

  task automatic drive_frame(input int fid, input bit gaps);
    for (int i = 0; i < FP; i++) begin
      if (gaps && (i % 3 == 1)) drive(0, 1, 12'hFFF);
      drive(1, (i == 0) || (i == 5), pix(fid, i));
    end
    drive(0, 0, '0);
  endtask

  task automatic wait_done(input int prev);
    int t = 0;
    while (done_n == prev && t < 300) begin @(negedge clk); t++; end
    check(done_n == prev + 1, "R6 done pulse count", done_n, prev + 1);
    @(negedge clk);
    check(busy_o == 0, "R7 idle after notice", busy_o, 0);
    check(done_n == prev + 1, "R6 single pulse", done_n, prev + 1);
  endtask

  task automatic check_frame(input int fid, input logic [AW-1:0] b, input int k, input bit ovf);
    check(wr_n == k, "R5 stored word count", wr_n, k);
    for (int i = 0; i < k && i < wr_n; i++) begin
      check(wr_addr[i] == b + AW'(i), "R3 address", wr_addr[i], b + AW'(i));
      check(wr_data[i] == {4'b0, pix(fid, i)}, "R3 zero-filled data", wr_data[i], {4'b0, pix(fid, i)});
    end
    check(d_addr == b, "R6 notice base", d_addr, b);
    check(d_len == LEN_W'(FP), "R6 notice length", d_len, FP);
    check(d_ovf == ovf, "R5 notice overflow", d_ovf, ovf);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check(busy_o == 0, "R9 busy", busy_o, 0);
    check(mem_valid_o == 0, "R9 mem_valid", mem_valid_o, 0);
    check(done_o == 0, "R9 done", done_o, 0);
    check(rej_cnt_o == 0, "R9 rej count", rej_cnt_o, 0);

    // R1 pixels while idle are ignored
    for (int i = 0; i < 4; i++) drive(1, 1, 12'h111);
    drive(0, 0, 0);
    repeat (3) tick();
    check(wr_n == 0, "R1 idle ignores pixels", wr_n, 0);
    check(busy_o == 0, "R1 idle stays idle", busy_o, 0);

    // Frame 1: R2 pre-marker pixels dropped, mid-frame marker ignored, refused start (R8)
    wr_n = 0;
    cmd_start(16'h0100);
    @(negedge clk);
    check(busy_o == 1, "R1 busy after start", busy_o, 1);
    drive(1, 0, 12'h777); drive(1, 0, 12'h778);
    fork
      drive_frame(1, 0);
      begin repeat (4) tick(); start_i = 1; base_addr_i = 16'h0900; tick(); start_i = 0; end
    join
    wait_done(0);
    check_frame(1, 16'h0100, FP, 0);
    check(rej_cnt_o == 1, "R8 refused start counted", rej_cnt_o, 1);

    // Frame 2: brief back-pressure with gaps (R4), no loss
    wr_n = 0;
    cmd_start(16'h0200);
    fork
      drive_frame(2, 1);
      begin repeat (3) tick(); mem_ready_i = 0; repeat (2) tick(); mem_ready_i = 1; end
    join
    wait_done(1);
    check_frame(2, 16'h0200, FP, 0);

    // Frame 3: memory stalled whole frame, overflow (R5, R6 waits for drain)
    wr_n = 0;
    mem_ready_i = 0;
    cmd_start(16'h0300);
    drive_frame(3, 0);
    repeat (4) tick();
    check(done_n == 2, "R6 no notice before drain", done_n, 2);
    check(busy_o == 1, "R6 busy while words pending", busy_o, 1);
    mem_ready_i = 1;
    wait_done(2);
    check_frame(3, 16'h0300, DEPTH, 1);

    // Frame 4: overflow flag cleared (R7), start held high saturates counter (R8)
    wr_n = 0;
    cmd_start(16'h0400);
    fork
      drive_frame(4, 0);
      begin tick(); start_i = 1; base_addr_i = 16'h0500; repeat (9) tick(); start_i = 0; end
    join
    wait_done(3);
    check_frame(4, 16'h0400, FP, 0);
    check(rej_cnt_o == 3'd7, "R8 saturation", rej_cnt_o, 7);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule